// File: doc/BRIEF.md
# Windowed Image Histogram Engine

The engine takes a raw pixel stream, one pixel per clock, and builds intensity histograms over up to four rectangular windows at the same time. The stream is qualified by a valid flag, a frame-start marker, a line-start marker and a last-pixel marker. The engine keeps its own column and row counters from these markers. Each pixel is first multiplied by a gain picked by its colour position and saturated to the input range. The result is then scaled down to a bin index. The counter for that bin is incremented in every active window that contains the pixel.

All windows share one bin memory of 32-bit words. Window 0's bins come first, then window 1's, and so on. The more windows are active, the fewer bins each may use. A small register bus holds the configuration, an enable bit and a busy flag. It also has a read-address register and a data port that steps through the memory. The data port can optionally zero each word as it returns it, so one readout pass both collects a capture and prepares the memory for the next one.

Top module: `histEngine`

## Requirements
- R1: After reset, control reads 0, configuration (address 1) reads 0, the gain register (address 2) reads 0x20 in every byte lane, and every bin word reads zero.
- R2: The bin index is the gained pixel shifted right by 10 minus log2 of the bin count. The bin count is selected by configuration bits [1:0]: 0 selects 32, 1 selects 64, 2 selects 128 and 3 selects 256.
- R3: Each gain is an unsigned 8-bit value with 5 fractional bits. The gained value is (pixel x gain) >> 5, clamped to 1023. Gain byte lane k (register 2, bits 8k+7..8k) is used when colour index k = {row[0], column[0]}.
- R4: When configuration bit 4 is set, the colour index is the column modulo 3 and gain lane 3 is never used.
- R5: The active window count is configuration bits [3:2] plus 1. A pixel counts in every active window with hStart<=column<=hEnd and vStart<=row<=vEnd. Pixels never count in inactive windows. Window r is set by register 8+2r (horizontal) and register 9+2r (vertical), with the start in bits [9:0] and the end in bits [25:16].
- R6: The bin of window r lives at word address r x bins + index.
- R7: With two windows the bin count is limited to 128. With three or four windows it is limited to 64. A larger request uses the limit.
- R8: A bin counter stops at its maximum value and does not wrap.
- R9: Writing register 3 sets the read address. Each read of register 4 returns the word at that address and then advances the address by one.
- R10: When configuration bit 5 is set, a read of register 4 zeroes the word it returns. When bit 5 is clear, reads leave the memory unchanged.
- R11: Control bit 0 is enable and bit 1 is busy (read-only). Busy rises the cycle after a frame-start pixel is taken while enabled. It falls two cycles after the last pixel, once that pixel's counts are stored. Clearing enable drops busy.
- R12: The engine ignores pixels while disabled, pixels with valid low, and pixels outside a frame that started while enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pixValid | input | 1 | Pixel qualifier |
| pixFrameStart | input | 1 | Marks the first pixel of a frame |
| pixLineStart | input | 1 | Marks the first pixel of a line |
| pixLast | input | 1 | Marks the last pixel of a frame |
| pixData | input | PIX_W | Raw pixel value |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from address |
| busy | output | 1 | Frame collection in progress |

## Verification
A wrong coordinate counter or colour index sends a count to the wrong bin word. A wrong gain lane does the same. This shows up on the first readout pass after the frame, because every bin word is compared against a model of the whole memory. A broken window limit or bin clamp corrupts the layout as well. It either puts a count at a truncated address, which gives a doubled count, or it leaves a count in an inactive window's range. Errors in busy or in the read-address register show on the very next register read.

// File: rtl/histPkg.sv
package histPkg;
  localparam int NUM_REG   = 4;
  localparam int CFA_N     = 4;
  localparam int MIN_LOG2  = 5;
  localparam int MAX_LOG2  = 8;
  localparam int MEM_AW    = MAX_LOG2;
  localparam int MEM_DEPTH = 1 << MEM_AW;
  localparam int GAIN_LANE = 8;
  localparam int END_LSB   = 16;

  localparam logic [3:0] A_CTRL   = 4'd0;
  localparam logic [3:0] A_CFG    = 4'd1;
  localparam logic [3:0] A_GAIN   = 4'd2;
  localparam logic [3:0] A_RDADDR = 4'd3;
  localparam logic [3:0] A_DATA   = 4'd4;

  typedef struct packed {
    logic       clearOnRead;
    logic       stacked;
    logic [1:0] regionsM1;
    logic [1:0] binSel;
  } histCfgT;

  typedef struct packed {
    logic accept;
    logic dataRead;
    logic clearOnRead;
  } histStrobeT;
endpackage

// File: rtl/histCtrl.sv
module histCtrl
  import histPkg::*;
#(
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COORD_W   = 10,
  parameter int CNT_W     = 32
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWrEn,
  input  logic                              regRdEn,
  input  logic [3:0]                        regAddr,
  input  logic [31:0]                       regWrData,
  output logic [31:0]                       regRdData,
  input  logic                              pixValid,
  input  logic                              pixFrameStart,
  input  logic                              pixLast,
  input  logic                              lastDone,
  input  logic [CNT_W-1:0]                  memRdWord,
  output histCfgT                           cfg,
  output histStrobeT                        strobe,
  output logic [MEM_AW-1:0]                 rdAddr,
  output logic [CFA_N-1:0][GAIN_W-1:0]      gains,
  output logic [NUM_REG-1:0][COORD_W-1:0]   hStart,
  output logic [NUM_REG-1:0][COORD_W-1:0]   hEnd,
  output logic [NUM_REG-1:0][COORD_W-1:0]   vStart,
  output logic [NUM_REG-1:0][COORD_W-1:0]   vEnd,
  output logic                              enableBit,
  output logic                              busy
);
  histCfgT                            cfgQ;
  logic                               enableQ, busyQ, inFrameQ;
  logic [MEM_AW-1:0]                  rdAddrQ;
  logic [CFA_N-1:0][GAIN_W-1:0]       gainQ;
  logic [NUM_REG-1:0][COORD_W-1:0]    hStartQ, hEndQ, vStartQ, vEndQ;
  logic                               accept, dataRead, addrWrite;

  assign accept    = pixValid && enableQ && (pixFrameStart || inFrameQ);
  assign dataRead  = regRdEn && (regAddr == A_DATA);
  assign addrWrite = regWrEn && (regAddr == A_RDADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      enableQ  <= 1'b0;
      busyQ    <= 1'b0;
      inFrameQ <= 1'b0;
      rdAddrQ  <= '0;
      hStartQ  <= '0;
      hEndQ    <= '0;
      vStartQ  <= '0;
      vEndQ    <= '0;
      for (int g = 0; g < CFA_N; g++) gainQ[g] <= GAIN_W'(1) << GAIN_FRAC;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          A_CTRL: enableQ <= regWrData[0];
          A_CFG:  cfgQ    <= histCfgT'(regWrData[5:0]);
          A_GAIN: for (int g = 0; g < CFA_N; g++)
                    gainQ[g] <= regWrData[g*GAIN_LANE +: GAIN_W];
          default: begin
            if (regAddr[3]) begin
              if (!regAddr[0]) begin
                hStartQ[regAddr[2:1]] <= regWrData[COORD_W-1:0];
                hEndQ[regAddr[2:1]]   <= regWrData[END_LSB +: COORD_W];
              end else begin
                vStartQ[regAddr[2:1]] <= regWrData[COORD_W-1:0];
                vEndQ[regAddr[2:1]]   <= regWrData[END_LSB +: COORD_W];
              end
            end
          end
        endcase
      end

      if (addrWrite)     rdAddrQ <= regWrData[MEM_AW-1:0];
      else if (dataRead) rdAddrQ <= rdAddrQ + 1'b1;

      // frame tracking: a disabled engine forgets any frame in progress
      if (!enableQ) begin
        inFrameQ <= 1'b0;
        busyQ    <= 1'b0;
      end else begin
        if (accept && pixLast)            inFrameQ <= 1'b0;
        else if (accept && pixFrameStart) inFrameQ <= 1'b1;
        if (accept && pixFrameStart)      busyQ <= 1'b1;
        else if (lastDone)                busyQ <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL:   regRdData[1:0] = {busyQ, enableQ};
      A_CFG:    regRdData[5:0] = cfgQ;
      A_GAIN:   for (int g = 0; g < CFA_N; g++)
                  regRdData[g*GAIN_LANE +: GAIN_W] = gainQ[g];
      A_RDADDR: regRdData[MEM_AW-1:0] = rdAddrQ;
      A_DATA:   regRdData[CNT_W-1:0] = memRdWord;
      default: begin
        if (regAddr[3]) begin
          if (!regAddr[0]) begin
            regRdData[COORD_W-1:0]         = hStartQ[regAddr[2:1]];
            regRdData[END_LSB +: COORD_W]  = hEndQ[regAddr[2:1]];
          end else begin
            regRdData[COORD_W-1:0]         = vStartQ[regAddr[2:1]];
            regRdData[END_LSB +: COORD_W]  = vEndQ[regAddr[2:1]];
          end
        end
      end
    endcase
  end

  assign cfg                = cfgQ;
  assign strobe.accept      = accept;
  assign strobe.dataRead    = dataRead;
  assign strobe.clearOnRead = cfgQ.clearOnRead;
  assign rdAddr             = rdAddrQ;
  assign gains              = gainQ;
  assign hStart             = hStartQ;
  assign hEnd               = hEndQ;
  assign vStart             = vStartQ;
  assign vEnd               = vEndQ;
  assign enableBit          = enableQ;
  assign busy               = busyQ;
endmodule

// File: rtl/histDatapath.sv
module histDatapath
  import histPkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COORD_W   = 10,
  parameter int CNT_W     = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             pixValid,
  input  logic                             pixFrameStart,
  input  logic                             pixLineStart,
  input  logic                             pixLast,
  input  logic [PIX_W-1:0]                 pixData,
  input  histCfgT                          cfg,
  input  histStrobeT                       strobe,
  input  logic [MEM_AW-1:0]                rdAddr,
  input  logic [CFA_N-1:0][GAIN_W-1:0]     gains,
  input  logic [NUM_REG-1:0][COORD_W-1:0]  hStart,
  input  logic [NUM_REG-1:0][COORD_W-1:0]  hEnd,
  input  logic [NUM_REG-1:0][COORD_W-1:0]  vStart,
  input  logic [NUM_REG-1:0][COORD_W-1:0]  vEnd,
  output logic [CNT_W-1:0]                 memRdWord,
  output logic                             lastDone,
  output logic [NUM_REG-1:0]               stageHit,
  output logic [1:0]                       effSel
);
  localparam int PROD_W = PIX_W + GAIN_W;
  localparam logic [PROD_W-1:0] PIX_MAX = PROD_W'({PIX_W{1'b1}});

  // pixel position
  logic [COORD_W-1:0] colQ, rowQ, curCol, curRow;
  logic [1:0]         phaseQ, curPhase;

  always_comb begin
    if (pixFrameStart) begin
      curCol = '0;
      curRow = '0;
    end else if (pixLineStart) begin
      curCol = '0;
      curRow = rowQ + 1'b1;
    end else begin
      curCol = colQ + 1'b1;
      curRow = rowQ;
    end
    if (pixFrameStart || pixLineStart) curPhase = 2'd0;
    else if (phaseQ == 2'd2)           curPhase = 2'd0;
    else                               curPhase = phaseQ + 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ   <= '0;
      rowQ   <= '0;
      phaseQ <= '0;
    end else if (pixValid) begin
      colQ   <= curCol;
      rowQ   <= curRow;
      phaseQ <= curPhase;
    end
  end

  // gain and saturation
  logic [1:0]        colourIdx;
  logic [GAIN_W-1:0] gainSel;
  logic [PROD_W-1:0] prod, scaled;
  logic [PIX_W-1:0]  gained;

  assign colourIdx = cfg.stacked ? curPhase : {curRow[0], curCol[0]};
  assign gainSel   = gains[colourIdx];
  assign prod      = PROD_W'(pixData) * PROD_W'(gainSel);
  assign scaled    = prod >> GAIN_FRAC;
  assign gained    = (scaled > PIX_MAX) ? '1 : scaled[PIX_W-1:0];

  // bin count clamp by window count, then index
  logic [1:0]        selLimit;
  logic [3:0]        log2Bins;
  logic [MEM_AW-1:0] binIdx;

  always_comb begin
    case (cfg.regionsM1)
      2'd0:    selLimit = 2'd3;
      2'd1:    selLimit = 2'd2;
      default: selLimit = 2'd1;
    endcase
    effSel   = (cfg.binSel > selLimit) ? selLimit : cfg.binSel;
    log2Bins = 4'(MIN_LOG2) + {2'b00, effSel};
    binIdx   = MEM_AW'(gained >> (PIX_W - MIN_LOG2 - int'(effSel)));
  end

  // per-window hit and address
  logic [NUM_REG-1:0]             hitNow;
  logic [NUM_REG-1:0][MEM_AW-1:0] addrNow, stageAddr;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_region
    logic              inWin;
    logic [MEM_AW+3:0] base;
    assign inWin = (curCol >= hStart[r]) && (curCol <= hEnd[r]) &&
                   (curRow >= vStart[r]) && (curRow <= vEnd[r]);
    assign hitNow[r]  = strobe.accept && inWin && (2'(r) <= cfg.regionsM1);
    assign base       = (MEM_AW+4)'(r) << log2Bins;
    assign addrNow[r] = base[MEM_AW-1:0] | binIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageHit  <= '0;
      stageAddr <= '0;
      lastDone  <= 1'b0;
    end else begin
      stageHit  <= hitNow;
      stageAddr <= addrNow;
      lastDone  <= strobe.accept && pixLast;
    end
  end

  // bin memory: windows never share a word, so four updates per cycle
  logic [CNT_W-1:0] binMem [MEM_DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) binMem[i] <= '0;
    end else begin
      for (int r = 0; r < NUM_REG; r++) begin
        if (stageHit[r] && (binMem[stageAddr[r]] != '1))
          binMem[stageAddr[r]] <= binMem[stageAddr[r]] + CNT_W'(1);
      end
      if (strobe.dataRead && strobe.clearOnRead) binMem[rdAddr] <= '0;
    end
  end

  assign memRdWord = binMem[rdAddr];
endmodule

// File: rtl/histEngine.sv
module histEngine
  import histPkg::*;
#(
  parameter int PIX_W     = 10,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 5,
  parameter int COORD_W   = 10,
  parameter int CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixValid,
  input  logic             pixFrameStart,
  input  logic             pixLineStart,
  input  logic             pixLast,
  input  logic [PIX_W-1:0] pixData,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  output logic             busy
);
  histCfgT                          cfg;
  histStrobeT                       strobe;
  logic [MEM_AW-1:0]                rdAddr;
  logic [CFA_N-1:0][GAIN_W-1:0]     gains;
  logic [NUM_REG-1:0][COORD_W-1:0]  hStart, hEnd, vStart, vEnd;
  logic [CNT_W-1:0]                 memRdWord;
  logic                             lastDone, enableBit, dataRead;
  logic [NUM_REG-1:0]               stageHit;
  logic [1:0]                       effSel, regionsM1;

  assign dataRead  = strobe.dataRead;
  assign regionsM1 = cfg.regionsM1;

  histCtrl #(
    .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .COORD_W(COORD_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .pixValid(pixValid), .pixFrameStart(pixFrameStart), .pixLast(pixLast),
    .lastDone(lastDone), .memRdWord(memRdWord),
    .cfg(cfg), .strobe(strobe), .rdAddr(rdAddr), .gains(gains),
    .hStart(hStart), .hEnd(hEnd), .vStart(vStart), .vEnd(vEnd),
    .enableBit(enableBit), .busy(busy)
  );

  histDatapath #(
    .PIX_W(PIX_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
    .COORD_W(COORD_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .pixValid(pixValid), .pixFrameStart(pixFrameStart),
    .pixLineStart(pixLineStart), .pixLast(pixLast), .pixData(pixData),
    .cfg(cfg), .strobe(strobe), .rdAddr(rdAddr), .gains(gains),
    .hStart(hStart), .hEnd(hEnd), .vStart(vStart), .vEnd(vEnd),
    .memRdWord(memRdWord), .lastDone(lastDone),
    .stageHit(stageHit), .effSel(effSel)
  );
endmodule

// File: rtl/histChecker.sv
module histChecker
  import histPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               enableBit,
  input logic               pixValid,
  input logic               pixFrameStart,
  input logic               lastDone,
  input logic               dataRead,
  input logic               regWrEn,
  input logic [3:0]         regAddr,
  input logic [MEM_AW-1:0]  rdAddr,
  input logic [NUM_REG-1:0] stageHit,
  input logic [1:0]         regionsM1,
  input logic [1:0]         effSel
);
  p_busy_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(enableBit && pixValid && pixFrameStart));

  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(lastDone || !enableBit));

  p_busy_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enableBit |=> !busy);

  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (dataRead && !(regWrEn && regAddr == A_RDADDR))
      |=> (rdAddr == $past(rdAddr) + 1'b1));

  p_inactive_region_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|stageHit) |-> ((stageHit & ~(4'hF >> (2'd3 - $past(regionsM1)))) == 4'h0));

  p_two_region_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regionsM1 == 2'd1) |-> (effSel <= 2'd2));

  p_many_region_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regionsM1 >= 2'd2) |-> (effSel <= 2'd1));
endmodule

bind histEngine histChecker u_histChecker (
  .clk(clk), .rstN(rstN), .busy(busy), .enableBit(enableBit),
  .pixValid(pixValid), .pixFrameStart(pixFrameStart), .lastDone(lastDone),
  .dataRead(dataRead), .regWrEn(regWrEn), .regAddr(regAddr),
  .rdAddr(rdAddr), .stageHit(stageHit), .regionsM1(regionsM1),
  .effSel(effSel)
);

// File: tb/tb_histEngine.sv
module tb_histEngine;
  localparam logic [3:0] CTRL = 4'd0, CFG = 4'd1, GAIN = 4'd2, RDADDR = 4'd3, DATA = 4'd4;
  localparam int WORDS = 256;
  localparam int NVEC  = 8;
  // {pixel[27:18], gain[17:10], binSel[9:8], expected index[7:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {10'd1023, 8'h20, 2'd3, 8'd255},
    {10'd100,  8'h20, 2'd0, 8'd3},
    {10'd100,  8'h40, 2'd3, 8'd50},
    {10'd600,  8'h40, 2'd2, 8'd127},
    {10'd512,  8'h10, 2'd1, 8'd16},
    {10'd7,    8'h28, 2'd3, 8'd2},
    {10'd0,    8'hFF, 2'd3, 8'd0},
    {10'd333,  8'h20, 2'd2, 8'd41}
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic pixValid = 0, pixFrameStart = 0, pixLineStart = 0, pixLast = 0;
  logic [9:0] pixData = '0;
  logic regWrEn = 0, regRdEn = 0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic busy;

  int total = 0, bad = 0;
  logic [31:0] expMem [WORDS];
  logic [31:0] cfgShadow = '0;
  logic [31:0] rd;

  always #4 clk = ~clk;

  histEngine #(.CNT_W(4)) dut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixFrameStart(pixFrameStart),
    .pixLineStart(pixLineStart), .pixLast(pixLast), .pixData(pixData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(posedge clk); #1; regWrEn = 0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); regRdEn = 1; regAddr = a;
    #1 d = regRdData;
    @(posedge clk); #1; regRdEn = 0;
  endtask

  task automatic setCfg(input logic [31:0] v);
    cfgShadow = v;
    regWrite(CFG, v);
  endtask

  task automatic setWin(input int r, input int hs, input int he, input int vs, input int ve);
    regWrite(4'(8 + 2*r), {6'd0, 10'(he), 6'd0, 10'(hs)});
    regWrite(4'(9 + 2*r), {6'd0, 10'(ve), 6'd0, 10'(vs)});
  endtask

  task automatic sendPix(input logic v, input logic fs, input logic ls,
                         input logic last, input logic [9:0] val);
    @(negedge clk);
    pixValid = v; pixFrameStart = fs; pixLineStart = ls; pixLast = last; pixData = val;
    @(posedge clk); #1;
    pixValid = 0; pixFrameStart = 0; pixLineStart = 0; pixLast = 0;
  endtask

  task automatic sendFrame(input int rows, input int cols, input logic [9:0] val);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++)
        sendPix(1'b1, r == 0 && c == 0, c == 0, r == rows-1 && c == cols-1, val);
  endtask

  // read the whole memory with clear-on-read and compare with the model
  task automatic drain(input string tag);
    logic [31:0] d, firstAct, firstExp;
    int mism;
    mism = 0; firstAct = '0; firstExp = '0;
    regWrite(CFG, cfgShadow | 32'h20);
    regWrite(RDADDR, 32'd0);
    for (int i = 0; i < WORDS; i++) begin
      regRead(DATA, d);
      if (d !== expMem[i] && mism == 0) begin
        firstAct = d; firstExp = expMem[i];
        $display("  word %0d differs", i);
      end
      if (d !== expMem[i]) mism++;
    end
    check(tag, firstAct, firstExp);
    for (int i = 0; i < WORDS; i++) expMem[i] = '0;
    regWrite(CFG, cfgShadow);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < WORDS; i++) expMem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    regRead(CTRL, rd);  check("R1 ctrl", rd, 32'h0);
    regRead(CFG, rd);   check("R1 cfg", rd, 32'h0);
    regRead(GAIN, rd);  check("R1 gain", rd, 32'h20202020);
    drain("R1 memory clear");

    regWrite(CTRL, 32'h1);

    // R2/R3 vector table: single window, one-pixel frames
    setWin(0, 0, 1023, 0, 1023);
    for (int v = 0; v < NVEC; v++) begin
      setCfg({26'd0, 1'b1, 1'b0, 2'd0, VEC[v][9:8]});
      regWrite(GAIN, {4{VEC[v][17:10]}});
      sendPix(1'b1, 1'b1, 1'b1, 1'b1, VEC[v][27:18]);
      expMem[VEC[v][7:0]] = 32'd1;
      drain($sformatf("R2 R3 vector %0d", v));
    end

    // R3 Bayer colour lanes: 2x2 frame of 400
    setCfg(32'h23);
    regWrite(GAIN, 32'h08104020);
    sendFrame(2, 2, 10'd400);
    expMem[100] = 1; expMem[200] = 1; expMem[50] = 1; expMem[25] = 1;
    drain("R3 bayer lanes");

    // R4 stacked mode: lane by column mod 3, lane 3 unused
    setCfg(32'h33);
    regWrite(GAIN, 32'hFF104020);
    sendFrame(1, 4, 10'd400);
    expMem[100] = 2; expMem[200] = 1; expMem[50] = 1;
    drain("R4 stacked lanes");

    // R5 R6 R7: four windows, 256 requested -> 64, inclusive edges
    setCfg(32'h2F);
    regWrite(GAIN, 32'h20202020);
    setWin(0, 0, 1, 0, 0);
    setWin(1, 1, 3, 0, 1);
    setWin(2, 2, 2, 1, 1);
    setWin(3, 5, 9, 0, 9);
    sendFrame(2, 4, 10'd160);
    expMem[10] = 2; expMem[74] = 6; expMem[138] = 1;
    drain("R5 R6 R7 four windows");

    // R7 two windows clamp to 128; R5 inactive windows ignored
    setCfg(32'h27);
    setWin(0, 0, 0, 0, 0);
    setWin(1, 0, 0, 0, 0);
    setWin(2, 0, 0, 0, 0);
    setWin(3, 0, 0, 0, 0);
    sendPix(1'b1, 1'b1, 1'b1, 1'b1, 10'd160);
    expMem[20] = 1; expMem[148] = 1;
    drain("R7 R5 two windows");

    // R8 saturation at 15 with the bench's 4-bit counters
    setCfg(32'h23);
    setWin(0, 0, 1023, 0, 1023);
    sendFrame(1, 20, 10'd0);
    expMem[0] = 15;
    drain("R8 counter saturation");

    // R11 busy timing
    sendPix(1'b1, 1'b1, 1'b1, 1'b0, 10'd40);
    regRead(CTRL, rd); check("R11 busy after start", rd, 32'h3);
    sendPix(1'b1, 1'b0, 1'b0, 1'b0, 10'd40);
    sendPix(1'b1, 1'b0, 1'b0, 1'b1, 10'd40);
    regRead(CTRL, rd); check("R11 busy until stored", rd, 32'h3);
    regRead(CTRL, rd); check("R11 busy falls", rd, 32'h1);
    expMem[10] = 3;
    drain("R11 frame counts");

    // R12 disabled, invalid and out-of-frame pixels ignored
    regWrite(CTRL, 32'h0);
    sendFrame(2, 2, 10'd40);
    regRead(CTRL, rd); check("R12 no busy while disabled", rd, 32'h0);
    regWrite(CTRL, 32'h1);
    sendPix(1'b1, 1'b0, 1'b1, 1'b0, 10'd80);
    sendPix(1'b0, 1'b1, 1'b1, 1'b1, 10'd80);
    sendFrame(1, 2, 10'd40);
    sendPix(1'b1, 1'b0, 1'b0, 1'b0, 10'd80);
    expMem[10] = 2;
    drain("R12 ignored pixels");

    // R9 R10 readout behaviour
    setCfg(32'h03);
    sendPix(1'b1, 1'b1, 1'b1, 1'b1, 10'd20);
    regWrite(RDADDR, 32'd4);
    regRead(DATA, rd); check("R9 word 4", rd, 32'd0);
    regRead(DATA, rd); check("R9 advanced to word 5", rd, 32'd1);
    regRead(RDADDR, rd); check("R9 address now 6", rd, 32'd6);
    regWrite(RDADDR, 32'd5);
    regRead(DATA, rd); check("R10 nondestructive read", rd, 32'd1);
    setCfg(32'h23);
    regWrite(RDADDR, 32'd5);
    regRead(DATA, rd); check("R10 clearing read returns value", rd, 32'd1);
    regWrite(RDADDR, 32'd5);
    regRead(DATA, rd); check("R10 word cleared", rd, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule